// File: doc/BRIEF.md
# Legacy Memory Window Attribute Decoder

This block sits beside a host bridge and decides, for every memory access below 1 MB, whether the read and the write side go to system RAM or to the expansion bus. Software programs it through byte-wide configuration writes. Seven attribute bytes hold thirteen 2-bit region fields. One field covers the 64 KB boot firmware area at the top of the first megabyte. The other twelve cover 16 KB slices of the adapter area that starts at 0xC0000. A separate control byte governs the 128 KB system-management window at 0xA0000.

The access side is purely combinational. An address and a flag that marks system-management mode go in. Three flags come out: read-to-RAM, write-to-RAM, and a flag that says the management window is currently seen as RAM. The configuration bytes are registered. A write changes the routing from the cycle after the write. Memory below the management window is always RAM.

Top module: `lmw_window_decoder`

## Requirements
- R1: After reset all attribute bytes are 0x00 and the window control byte is 0x02. As a result, every region routes reads and writes to the bus, and the window is bus for both SMM and non-SMM accesses.
- R2: Any address below 0xA0000 gives rd_ram=1 and wr_ram=1, whatever the configuration and the SMM flag.
- R3: A region field uses its low bit as read-to-RAM and its high bit as write-to-RAM:
  - 00 sends both to the bus.
  - 01 sends reads to RAM only.
  - 10 sends writes to RAM only.
  - 11 sends both to RAM.
  - Bits 7:6 and 3:2 of an attribute byte have no effect.
- R4: The firmware region 0xF0000–0xFFFFF takes its field from bits 5:4 of offset 0x59.
- R5: Adapter region k (k=1..12) covers 0xC0000+(k-1)*0x4000 for 16 KB. Its field sits in the byte at offset 0x59+ceil(k/2): bits 1:0 when k is odd, bits 5:4 when k is even. The SMM flag has no effect on these regions.
- R6: A non-SMM access to 0xA0000–0xBFFFF goes to RAM (both sides) only when the open bit, bit 6 of offset 0x72, is set; otherwise it goes to the bus.
- R7: An SMM access to 0xA0000–0xBFFFF goes to RAM (both sides) when either the enable bit (bit 3 of offset 0x72) or the open bit is set; otherwise it goes to the bus.
- R8: A configuration write to offsets 0x59–0x5F or 0x72 takes effect on the cycle after it is accepted. A write to any other offset changes nothing.
- R9: smram_ram is 1 exactly when the address lies in 0xA0000–0xBFFFF and that access is routed to RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| mem_addr | input | 20 | Access address below 1 MB |
| mem_smm | input | 1 | Access is issued in system-management mode |
| rd_ram | output | 1 | Reads of this address go to RAM (0: bus) |
| wr_ram | output | 1 | Writes to this address go to RAM (0: bus) |
| smram_ram | output | 1 | Address is in the management window and routed to RAM |

## Verification
Some properties are checked on every cycle:
- the low-memory rule;
- the closed-window rule for non-SMM masters;
- the enable rule for SMM masters;
- the consistency of smram_ram with the address and routing;
- that stray configuration writes leave the stored bytes untouched and that a control write lands.

Other behaviour can only be shown by the bench's scenarios:
- which nibble of which byte feeds each of the thirteen regions;
- the exact region edges at 16 KB boundaries;
- that the unused field bits have no effect;
- the one-cycle write latency.

// File: rtl/lmw_pkg.sv
package lmw_pkg;
    localparam int ADDR_W = 20;
    localparam int IDX_W  = 4;

    localparam logic [7:0] ATTR_BASE_OFF = 8'h59;
    localparam int         ATTR_BYTES    = 7;
    localparam logic [7:0] WIN_CTRL_OFF  = 8'h72;
    localparam logic [7:0] WIN_CTRL_RST  = 8'h02;

    localparam int OPEN_BIT   = 6;
    localparam int ENABLE_BIT = 3;
    localparam int FLD_HI_LSB = 4;
    localparam int FLD_LO_LSB = 0;

    localparam logic [ADDR_W-1:0] WIN_BASE  = 20'hA0000;
    localparam logic [ADDR_W-1:0] WIN_END   = 20'hC0000;
    localparam logic [ADDR_W-1:0] EXP_BASE  = 20'hC0000;
    localparam logic [ADDR_W-1:0] BIOS_BASE = 20'hF0000;
endpackage

// File: rtl/lmw_cfg_regs.sv
module lmw_cfg_regs
    import lmw_pkg::*;
#(
    parameter int NBYTES = ATTR_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [7:0]            cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [NBYTES-1:0][7:0] attr_q,
    output logic [7:0]            ctrl_q
);
    localparam int SEL_W = $clog2(NBYTES);

    typedef struct packed {
        logic [NBYTES-1:0][7:0] attr;
        logic [7:0]             ctrl;
    } cfg_t;

    cfg_t st_d, st_q;
    logic attr_hit, ctrl_hit;

    always_comb begin
        attr_hit = (cfg_addr >= ATTR_BASE_OFF) &&
                   (cfg_addr <  ATTR_BASE_OFF + 8'(NBYTES));
        ctrl_hit = (cfg_addr == WIN_CTRL_OFF);
        st_d = st_q;
        if (cfg_we && attr_hit)
            st_d.attr[SEL_W'(cfg_addr - ATTR_BASE_OFF)] = cfg_wdata;
        if (cfg_we && ctrl_hit)
            st_d.ctrl = cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.attr <= '0;
            st_q.ctrl <= WIN_CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign attr_q = st_q.attr;
    assign ctrl_q = st_q.ctrl;

    // R8: stray offsets leave every stored byte untouched
    assert_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !attr_hit && !ctrl_hit) |=> $stable(st_q));

    // R8: a control write is visible on the next cycle
    assert_ctrl_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == WIN_CTRL_OFF) |=> (ctrl_q == $past(cfg_wdata)));
endmodule

// File: rtl/lmw_region_map.sv
module lmw_region_map
    import lmw_pkg::*;
#(
    parameter int NUM_EXP   = 12,
    parameter int EXP_SHIFT = 14
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              bios_hit,
    output logic              exp_hit,
    output logic              win_hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int TAG_W = ADDR_W - EXP_SHIFT;

    logic [NUM_EXP-1:0] exp_sel;

    for (genvar k = 0; k < NUM_EXP; k++) begin : g_exp
        localparam logic [ADDR_W-1:0] SLICE_BASE = EXP_BASE + ADDR_W'(k << EXP_SHIFT);
        assign exp_sel[k] = (addr[ADDR_W-1:EXP_SHIFT] == SLICE_BASE[ADDR_W-1:EXP_SHIFT]);
    end

    always_comb begin
        bios_hit = (addr >= BIOS_BASE);
        win_hit  = (addr >= WIN_BASE) && (addr < WIN_END);
        exp_hit  = |exp_sel;
        idx      = '0;
        for (int k = 0; k < NUM_EXP; k++) begin
            if (exp_sel[k]) idx = IDX_W'(k + 1);
        end
    end

    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;
endmodule

// File: rtl/lmw_route.sv
module lmw_route
    import lmw_pkg::*;
#(
    parameter int NBYTES = ATTR_BYTES
) (
    input  logic [NBYTES-1:0][7:0] attr,
    input  logic                   win_open,
    input  logic                   win_enable,
    input  logic                   bios_hit,
    input  logic                   exp_hit,
    input  logic                   win_hit,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   smm,
    output logic                   rd_ram,
    output logic                   wr_ram,
    output logic                   win_ram
);
    localparam int SEL_W = $clog2(NBYTES);

    logic [SEL_W-1:0] bsel;
    logic [7:0]       byte_v;
    logic             use_hi;
    logic [1:0]       fld;
    logic             ram_v;

    always_comb begin
        bsel   = SEL_W'((32'(idx) + 1) >> 1);
        byte_v = attr[bsel];
        use_hi = (idx == '0) || !idx[0];
        fld    = use_hi ? byte_v[FLD_HI_LSB +: 2] : byte_v[FLD_LO_LSB +: 2];
        ram_v  = smm ? (win_open || win_enable) : win_open;
        rd_ram  = 1'b1;
        wr_ram  = 1'b1;
        win_ram = 1'b0;
        if (win_hit) begin
            rd_ram  = ram_v;
            wr_ram  = ram_v;
            win_ram = ram_v;
        end else if (bios_hit || exp_hit) begin
            rd_ram = fld[0];
            wr_ram = fld[1];
        end
    end
endmodule

// File: rtl/lmw_window_decoder.sv
module lmw_window_decoder
    import lmw_pkg::*;
#(
    parameter int NUM_EXP   = 12,
    parameter int EXP_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_smm,
    output logic              rd_ram,
    output logic              wr_ram,
    output logic              smram_ram
);
    localparam int NBYTES = (NUM_EXP + 2) / 2;

    logic [NBYTES-1:0][7:0] attr_q;
    logic [7:0]             ctrl_q;
    logic                   bios_hit, exp_hit, win_hit;
    logic [IDX_W-1:0]       idx;

    lmw_cfg_regs #(.NBYTES(NBYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .attr_q(attr_q), .ctrl_q(ctrl_q)
    );

    lmw_region_map #(.NUM_EXP(NUM_EXP), .EXP_SHIFT(EXP_SHIFT)) u_map (
        .addr(mem_addr), .bios_hit(bios_hit), .exp_hit(exp_hit),
        .win_hit(win_hit), .idx(idx)
    );

    lmw_route #(.NBYTES(NBYTES)) u_route (
        .attr(attr_q), .win_open(ctrl_q[OPEN_BIT]), .win_enable(ctrl_q[ENABLE_BIT]),
        .bios_hit(bios_hit), .exp_hit(exp_hit), .win_hit(win_hit), .idx(idx),
        .smm(mem_smm), .rd_ram(rd_ram), .wr_ram(wr_ram), .win_ram(smram_ram)
    );

    // R2: low memory is RAM for any configuration
    assert_low_ram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr < WIN_BASE) |-> (rd_ram && wr_ram));

    // R6: closed window hides RAM from non-SMM masters
    assert_closed_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >= WIN_BASE && mem_addr < WIN_END && !mem_smm && !ctrl_q[OPEN_BIT])
        |-> (!rd_ram && !wr_ram));

    // R7: enabled window is RAM for SMM masters
    assert_smm_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr >= WIN_BASE && mem_addr < WIN_END && mem_smm && ctrl_q[ENABLE_BIT])
        |-> (rd_ram && wr_ram));

    // R9: the window flag only rises inside the window while routed to RAM
    assert_win_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        smram_ram |-> (mem_addr >= WIN_BASE && mem_addr < WIN_END && rd_ram && wr_ram));
endmodule

// File: tb/sim_lmw_window_decoder.sv
module sim_lmw_window_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [19:0] mem_addr = '0;
    logic        mem_smm = 1'b0;
    logic        rd_ram, wr_ram, smram_ram;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmw_window_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mem_addr(mem_addr), .mem_smm(mem_smm),
        .rd_ram(rd_ram), .wr_ram(wr_ram), .smram_ram(smram_ram)
    );

    // {addr, smm, rd, wr, win} after the programming below
    localparam logic [23:0] VEC [NVEC] = '{
        {20'hF0000, 4'b0100}, {20'hFFFFF, 4'b0100},
        {20'hC0000, 4'b0010}, {20'hC3FFF, 4'b0010},
        {20'hC4000, 4'b0110}, {20'hC8000, 4'b0100},
        {20'hCC000, 4'b0000}, {20'hD0000, 4'b0110},
        {20'hD4000, 4'b0010}, {20'hD8000, 4'b0000},
        {20'hDC000, 4'b0100}, {20'hE0000, 4'b0110},
        {20'hE4000, 4'b0000}, {20'hE8000, 4'b0010},
        {20'hEFFFF, 4'b0000}, {20'h9FFFF, 4'b0110},
        {20'h00000, 4'b1110}, {20'hA0000, 4'b0000},
        {20'hA0000, 4'b1111}, {20'hBFFFF, 4'b1111},
        {20'hC0000, 4'b1010}
    };

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [19:0] a, input logic s, input logic [2:0] exp,
                         input string req);
        @(negedge clk);
        mem_addr = a; mem_smm = s;
        #1;
        total++;
        if ({rd_ram, wr_ram, smram_ram} !== exp) begin
            bad++;
            $display("FAIL %s addr=%05h smm=%0b actual=%03b expected=%03b",
                     req, a, s, {rd_ram, wr_ram, smram_ram}, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset routing
        probe(20'hF0000, 1'b0, 3'b000, "R1");
        probe(20'hD4000, 1'b0, 3'b000, "R1");
        probe(20'hA0000, 1'b1, 3'b000, "R1");
        probe(20'h05000, 1'b1, 3'b110, "R2");
        // programming for the table (R3 R4 R5; unused bits set in 0x5E and 0x5F)
        cfg_write(8'h59, 8'h10);
        cfg_write(8'h5A, 8'h32);
        cfg_write(8'h5B, 8'h01);
        cfg_write(8'h5C, 8'h23);
        cfg_write(8'h5D, 8'h10);
        cfg_write(8'h5E, 8'h0F);
        cfg_write(8'h5F, 8'hC2);
        cfg_write(8'h72, 8'h0A);
        for (int i = 0; i < NVEC; i++) begin
            probe(VEC[i][23:4], VEC[i][3], VEC[i][2:0], "R3/R4/R5/R6/R7/R9 table");
        end
        // R8: stray offsets change nothing
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        cfg_write(8'h71, 8'hFF);
        cfg_write(8'h73, 8'hFF);
        probe(20'hC0000, 1'b0, 3'b010, "R8");
        probe(20'hD8000, 1'b0, 3'b000, "R8");
        probe(20'hA0000, 1'b0, 3'b000, "R8");
        // R8: one-cycle latency, probed in the very next cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h59; cfg_wdata = 8'h30; mem_addr = 20'hF0000; mem_smm = 1'b0;
        #1;
        total++;
        if ({rd_ram, wr_ram} !== 2'b10) begin
            bad++;
            $display("FAIL R8 before edge actual=%02b expected=10", {rd_ram, wr_ram});
        end
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        total++;
        if ({rd_ram, wr_ram} !== 2'b11) begin
            bad++;
            $display("FAIL R8 after edge actual=%02b expected=11", {rd_ram, wr_ram});
        end
        // R6 R7 R9: open bit alone
        cfg_write(8'h72, 8'h40);
        probe(20'hB0000, 1'b0, 3'b111, "R6");
        probe(20'hB0000, 1'b1, 3'b111, "R7");
        // R7: neither bit
        cfg_write(8'h72, 8'h00);
        probe(20'hA1234, 1'b1, 3'b000, "R7");
        probe(20'hBFFFF, 1'b0, 3'b000, "R6");
        probe(20'h9FFFF, 1'b1, 3'b110, "R2");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule